// File: doc/BRIEF.md
# Variable-Width Serial Master Shift Engine

This block is the bit-level engine of a serial peripheral master. It pulls 32-bit words from a transmit queue that sits outside it. Each word carries its own bit count in the top byte and up to 24 payload bits in the lower part. For every non-empty word the engine shifts out that many bits on MOSI and captures the same number of bits from MISO. It then pushes one right-justified receive word to a receive queue that also sits outside it.

The serial clock is derived from the system clock by a programmable divider. Its idle level can be selected. The edge that changes MOSI and the edge that samples MISO are selected separately, and so is the bit order on each direction. The word's sideband flag decides whether the three active-low chip-select lines stay asserted after the word ends. This lets several words form one framed transaction. Chunks are always separated by an idle gap of at least two serial-clock periods. A busy flag and a bits-remaining count show where the engine is.

Top module: `vwspi_engine`

## Requirements
- R1: Every SCK transition inside a chunk is exactly `div_sel`+1 system clocks after the previous one, so the SCK frequency is the system clock divided by 2×(`div_sel`+1).
- R2: Outside a chunk SCK rests at the level of `cpol`, and it returns to that level after the last transition of a chunk.
- R3: The bit count K is `tx_word[31:24]`. A chunk makes exactly 2×K SCK transitions. A count above 24 is treated as 24.
- R4: With `out_msb_first`=1 the payload goes out from `tx_word[23]` downward, so a 3-byte word sends bits 23:16 first. With `out_msb_first`=0 the payload goes out from `tx_word[0]` upward.
- R5: MOSI changes only on SCK transitions of the kind picked by `out_rise` (1 = rising), and never on the first transition of a chunk. The first bit is driven before the first transition. MISO is sampled on transitions of the kind picked by `in_rise` (1 = rising).
- R6: Each chunk produces exactly one single-cycle `rx_valid` pulse. `rx_data` holds the K received bits right-justified, with bits 31:K zero. With `in_msb_first`=1 the first received bit lands in bit K-1. With `in_msb_first`=0 it lands in bit 0.
- R7: At least two SCK periods (4×(`div_sel`+1) system clocks) pass between the last SCK transition of a chunk and the first transition of the next one.
- R8: All three `cs_n` lines fall together when a chunk starts and always carry the same value. If the word's `tx_keep_cs` is 0, they rise exactly 2×(`div_sel`+1) system clocks after the chunk's last SCK transition. If it is 1, they stay low into the next chunk.
- R9: `busy` is high exactly while chip select is asserted. `bits_left` equals K when the chunk starts, drops by one at each sampling transition, and is 0 when the chunk has ended.
- R10: A word with bit count 0 is consumed (`tx_pop`) but causes no SCK transition and no `rx_valid`, and it leaves chip select as it was.
- R11: After reset `cs_n` is all ones and `busy`, `rx_valid` and `bits_left` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 12 | Clock divider N, SCK = clk / (2×(N+1)) |
| cpol | input | 1 | Idle level of SCK |
| out_rise | input | 1 | 1: MOSI changes on rising SCK, 0: on falling |
| in_rise | input | 1 | 1: MISO sampled on rising SCK, 0: on falling |
| out_msb_first | input | 1 | Transmit bit order |
| in_msb_first | input | 1 | Receive assembly order |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_word | input | 32 | Head word: bit count in 31:24, payload in 23:0 |
| tx_keep_cs | input | 1 | Keep chip select asserted after this word |
| tx_pop | output | 1 | Head word consumed this cycle |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 3 | Active-low chip selects, driven together |
| rx_valid | output | 1 | One-cycle push of a received word |
| rx_data | output | 32 | Right-justified received bits |
| busy | output | 1 | Chip select currently asserted |
| bits_left | output | 5 | Bits still to be sampled in the current chunk |

## Verification
The case most likely to break is when the final MISO sample and the end of the chunk fall on the same SCK transition. This happens whenever sampling uses the trailing edge. In that cycle the receive push, the bits-remaining count reaching zero and the hand-over into the tail gap all happen together. The bench runs both trailing-edge and leading-edge sampling modes and judges the pushed word bit by bit against the slave's stream. It also checks that chip select rises exactly two half-periods later. A second case is a held chip select meeting a zero-count word at the same instant the next word could start; it is judged by the number of chip-select rises and by the pop count.

// File: rtl/vwspi_pkg.sv
package vwspi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } vwspi_state_t;

  // Tail length in half periods; chip select may drop at RELEASE_AT.
  localparam int TAIL_HALVES = 4;
  localparam int RELEASE_AT  = 1;

endpackage

// File: rtl/vwspi_clkdiv.sv
module vwspi_clkdiv #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= '0;
    else if (cnt == div)   cnt <= '0;
    else                   cnt <= cnt + DIV_W'(1);
  end

  assign tick = run && (cnt == div);

endmodule

// File: rtl/vwspi_txsh.sv
module vwspi_txsh #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              msb_first,
  input  logic              advance,
  output logic              mosi
);

  logic [DATA_W-1:0] sreg;
  logic              ord_msb;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      ord_msb <= 1'b1;
    end else if (load) begin
      sreg    <= load_data;
      ord_msb <= msb_first;
    end else if (advance) begin
      if (ord_msb) sreg <= {sreg[DATA_W-2:0], 1'b0};
      else         sreg <= {1'b0, sreg[DATA_W-1:1]};
    end
  end

  assign mosi = ord_msb ? sreg[DATA_W-1] : sreg[0];

  // R4: the sequencer never asks for a shift while it is loading a word.
  a_r4_no_shift_on_load: assert property (@(posedge clk) disable iff (rst)
    load |-> !advance);

endmodule

// File: rtl/vwspi_rxasm.sv
module vwspi_rxasm #(
  parameter int DATA_W = 24,
  localparam int IDX_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              msb_first,
  input  logic              sample,
  input  logic              miso,
  output logic [DATA_W-1:0] data
);

  logic [IDX_W-1:0] idx;
  logic             ord_msb;

  always_ff @(posedge clk) begin
    if (rst) begin
      data    <= '0;
      idx     <= '0;
      ord_msb <= 1'b1;
    end else if (clear) begin
      data    <= '0;
      idx     <= '0;
      ord_msb <= msb_first;
    end else if (sample) begin
      idx <= idx + IDX_W'(1);
      if (ord_msb) data <= {data[DATA_W-2:0], miso};
      else         data[idx] <= miso;
    end
  end

  // R6: never more samples in a chunk than the payload can hold.
  a_r6_sample_in_range: assert property (@(posedge clk) disable iff (rst)
    sample |-> (idx < IDX_W'(DATA_W)));

endmodule

// File: rtl/vwspi_engine.sv
module vwspi_engine
  import vwspi_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int DATA_W   = 24,
  parameter int DIV_W    = 12,
  parameter int CS_LINES = 3,
  localparam int CNT_W   = WORD_W - DATA_W,
  localparam int LEFT_W  = $clog2(DATA_W + 1),
  localparam int ECNT_W  = LEFT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              cpol,
  input  logic              out_rise,
  input  logic              in_rise,
  input  logic              out_msb_first,
  input  logic              in_msb_first,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_keep_cs,
  output logic              tx_pop,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [CS_LINES-1:0] cs_n,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic [LEFT_W-1:0] bits_left
);

  vwspi_state_t       st;
  logic               sck_q;
  logic [ECNT_W-1:0]  ecnt;
  logic [ECNT_W-1:0]  last_idx;
  logic [1:0]         gcnt;
  logic [LEFT_W-1:0]  nbits;
  logic [LEFT_W-1:0]  left_q;
  logic               keep_q;
  logic [CS_LINES-1:0] cs_n_q;
  logic               busy_q;
  logic               rx_valid_q;
  logic               tick;

  // Word decode: count field above the payload, limited to payload width.
  logic [CNT_W-1:0]   kfield;
  logic [LEFT_W-1:0]  k_eff;
  logic               accept, load;

  assign kfield = tx_word[WORD_W-1 -: CNT_W];
  assign k_eff  = (kfield > CNT_W'(DATA_W)) ? LEFT_W'(DATA_W) : LEFT_W'(kfield);
  assign accept = (st == ST_IDLE) && tx_valid;
  assign load   = accept && (kfield != '0);
  assign tx_pop = accept;

  // Edge classification: the next SCK transition is rising when SCK is low.
  logic in_shift, rising_next, in_edge, out_edge, last_edge;

  assign in_shift    = (st == ST_SHIFT);
  assign rising_next = ~sck_q;
  assign last_idx    = {nbits, 1'b0} - ECNT_W'(1);
  assign in_edge     = tick && in_shift && (rising_next == in_rise);
  assign out_edge    = tick && in_shift && (rising_next == out_rise) && (ecnt != '0);
  assign last_edge   = tick && in_shift && (ecnt == last_idx);

  vwspi_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (st != ST_IDLE),
    .div  (div_sel),
    .tick (tick)
  );

  vwspi_txsh #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (tx_word[DATA_W-1:0]),
    .msb_first (out_msb_first),
    .advance   (out_edge),
    .mosi      (mosi)
  );

  logic [DATA_W-1:0] rx_bits;

  vwspi_rxasm #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .clear     (load),
    .msb_first (in_msb_first),
    .sample    (in_edge),
    .miso      (miso),
    .data      (rx_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      sck_q      <= cpol;
      ecnt       <= '0;
      gcnt       <= '0;
      nbits      <= '0;
      left_q     <= '0;
      keep_q     <= 1'b0;
      cs_n_q     <= '1;
      busy_q     <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= in_edge && (left_q == LEFT_W'(1));
      if (in_edge) left_q <= left_q - LEFT_W'(1);
      unique case (st)
        ST_IDLE: begin
          sck_q <= cpol;
          if (load) begin
            st     <= ST_SHIFT;
            ecnt   <= '0;
            nbits  <= k_eff;
            left_q <= k_eff;
            keep_q <= tx_keep_cs;
            cs_n_q <= '0;
            busy_q <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sck_q <= ~sck_q;
            ecnt  <= ecnt + ECNT_W'(1);
            if (last_edge) begin
              st   <= ST_TAIL;
              gcnt <= '0;
            end
          end
        end
        ST_TAIL: begin
          sck_q <= cpol;
          if (tick) begin
            gcnt <= gcnt + 2'd1;
            if (gcnt == 2'(RELEASE_AT) && !keep_q) begin
              cs_n_q <= '1;
              busy_q <= 1'b0;
            end
            if (gcnt == 2'(TAIL_HALVES - 1)) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sck       = sck_q;
  assign cs_n      = cs_n_q;
  assign busy      = busy_q;
  assign bits_left = left_q;
  assign rx_valid  = rx_valid_q;
  assign rx_data   = {{(WORD_W-DATA_W){1'b0}}, rx_bits};

  // R1: inside a chunk SCK only moves on a divider tick.
  a_r1_sck_on_tick: assert property (@(posedge clk) disable iff (rst)
    (in_shift && $past(st) == ST_SHIFT && !$stable(sck_q)) |-> $past(tick));

  // R2: while idle with a steady polarity setting, SCK rests at that level.
  a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && $stable(cpol)) |-> (sck_q == cpol));

  // R3: the transition counter never runs past the chunk's last transition.
  a_r3_edge_bound: assert property (@(posedge clk) disable iff (rst)
    in_shift |-> (ecnt <= last_idx));

  // R6: a receive push is a single-cycle pulse.
  a_r6_single_push: assert property (@(posedge clk) disable iff (rst)
    rx_valid_q |=> !rx_valid_q);

  // R8: chip select is only released from the tail gap.
  a_r8_release_in_tail: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_q[0]) |-> ($past(st) == ST_TAIL));

  // R9: busy mirrors an asserted chip select; remaining count stays bounded.
  a_r9_busy_cs: assert property (@(posedge clk) disable iff (rst)
    busy_q == (cs_n_q == '0));
  a_r9_left_bound: assert property (@(posedge clk) disable iff (rst)
    left_q <= LEFT_W'(DATA_W));

  // R10: an empty word leaves the engine idle.
  a_r10_empty_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (accept && !load) |=> (st == ST_IDLE));

endmodule

// File: tb/vwspi_engine_bench.sv
module vwspi_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] div_sel = '0;
  logic        cpol = 1'b0, out_rise = 1'b0, in_rise = 1'b1;
  logic        out_msb_first = 1'b1, in_msb_first = 1'b1;
  logic        tx_valid, tx_keep_cs, tx_pop, miso, sck, mosi;
  logic [31:0] tx_word, rx_data;
  logic [2:0]  cs_n;
  logic        rx_valid, busy;
  logic [4:0]  bits_left;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Transmit queue model
  logic [31:0] qw [8];
  logic        qk [8];
  int          qn = 0;
  int          qidx;
  assign tx_valid   = (qidx < qn);
  assign tx_word    = tx_valid ? qw[qidx] : 32'h0;
  assign tx_keep_cs = tx_valid ? qk[qidx] : 1'b0;
  always @(posedge clk) begin
    if (rst) qidx <= 0;
    else if (tx_pop) qidx <= qidx + 1;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Slave model and monitor
  logic [127:0] sseq = '0;
  int  sidx, ne, nm, nr, ncr, mosi_bad, cs_mix, bl_start;
  logic busy_start, sck_prev, cs_prev, mosi_prev;
  int  edge_t [128];
  logic mcap [128];
  logic [31:0] rxw [8];
  int  cs_rise_t;
  assign miso = sseq[sidx[6:0]];

  always @(negedge clk) begin
    if (rst) begin
      sidx = 0; ne = 0; nm = 0; nr = 0; ncr = 0; mosi_bad = 0; cs_mix = 0;
      bl_start = -1; busy_start = 1'b0; cs_rise_t = -1;
      sck_prev = sck; cs_prev = 1'b1; mosi_prev = mosi;
    end else begin
      if (sck !== sck_prev) begin
        if (ne < 128) edge_t[ne] = cyc;
        ne = ne + 1;
        if (sck == in_rise) begin
          if (mosi !== mosi_prev) mosi_bad = mosi_bad + 1;
          if (nm < 128) mcap[nm] = mosi;
          nm = nm + 1;
          sidx = sidx + 1;
        end
      end
      if (cs_n !== 3'b000 && cs_n !== 3'b111) cs_mix = cs_mix + 1;
      if (cs_prev && !cs_n[0]) begin bl_start = bits_left; busy_start = busy; end
      if (!cs_prev && cs_n[0]) begin ncr = ncr + 1; cs_rise_t = cyc; end
      if (rx_valid) begin if (nr < 8) rxw[nr] = rx_data; nr = nr + 1; end
      sck_prev = sck; cs_prev = cs_n[0]; mosi_prev = mosi;
    end
  end

  vwspi_engine u_vwspi_engine (
    .clk(clk), .rst(rst), .div_sel(div_sel), .cpol(cpol), .out_rise(out_rise),
    .in_rise(in_rise), .out_msb_first(out_msb_first), .in_msb_first(in_msb_first),
    .tx_valid(tx_valid), .tx_word(tx_word), .tx_keep_cs(tx_keep_cs), .tx_pop(tx_pop),
    .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_data(rx_data), .busy(busy), .bits_left(bits_left)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input int d, input logic p, input logic orr, input logic irr,
                       input logic om, input logic im, input logic [127:0] s);
    rst = 1'b1;
    div_sel = 12'(d); cpol = p; out_rise = orr; in_rise = irr;
    out_msb_first = om; in_msb_first = im; sseq = s;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!(qidx == qn && !busy) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (6 * (int'(div_sel) + 1) + 4) @(negedge clk);
  endtask

  // Compare the captured MOSI bits and the pushed word of one chunk.
  task automatic check_chunk(input string tg, input int base, input logic [23:0] pl,
                             input int k, input int ri);
    logic [31:0] got = '0, exp = '0, er = '0;
    for (int i = 0; i < k; i++) begin
      got = {got[30:0], mcap[base+i]};
      exp = {exp[30:0], out_msb_first ? pl[23-i] : pl[i]};
      if (in_msb_first) er[k-1-i] = sseq[base+i];
      else              er[i]     = sseq[base+i];
    end
    chk(got == exp, {tg, " R4 mosi order"}, got, exp);
    chk(rxw[ri] == er, {tg, " R6 rx word"}, rxw[ri], er);
  endtask

  task automatic t_reset();
    qn = 0;
    setup(1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '0);
    repeat (3) @(negedge clk);
    chk(cs_n == 3'b111, "R11 cs_n after reset", cs_n, 3'b111);
    chk({busy, rx_valid, tx_pop} == 3'b000, "R11 flags after reset", {busy, rx_valid, tx_pop}, 0);
    chk(bits_left == 0, "R11 bits_left after reset", bits_left, 0);
    chk(sck == 1'b0, "R2 idle sck after reset", sck, 0);
  endtask

  task automatic t_mode0_msb();
    qw[0] = {8'd8, 24'hA5_0000}; qk[0] = 1'b0; qn = 1;
    setup(1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 128'h3C96);
    wait_done();
    chk(ne == 16, "R3 edges for 8 bits", ne, 16);
    chk(edge_t[1] - edge_t[0] == 2, "R1 half period d=1", edge_t[1] - edge_t[0], 2);
    chk(edge_t[9] - edge_t[8] == 2, "R1 half period mid chunk", edge_t[9] - edge_t[8], 2);
    check_chunk("mode0", 0, 24'hA5_0000, 8, 0);
    chk(nr == 1, "R6 one push", nr, 1);
    chk(cs_rise_t - edge_t[15] == 4, "R8 release delay", cs_rise_t - edge_t[15], 4);
    chk(sck == 1'b0, "R2 sck back at idle", sck, 0);
    chk(mosi_bad == 0 && cs_mix == 0, "R5 R8 mosi stable at sample, cs together", mosi_bad + cs_mix, 0);
  endtask

  task automatic t_cpol1_lsb();
    qw[0] = {8'd12, 24'h000_B3D}; qk[0] = 1'b0; qn = 1;
    setup(3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 128'hE4_71A5);
    wait_done();
    chk(ne == 24, "R3 edges for 12 bits", ne, 24);
    chk(edge_t[1] - edge_t[0] == 4, "R1 half period d=3", edge_t[1] - edge_t[0], 4);
    check_chunk("cpol1 lsb R5", 0, 24'h000_B3D, 12, 0);
    chk(rxw[0][31:12] == 0, "R6 upper bits zero", rxw[0][31:12], 0);
    chk(sck == 1'b1, "R2 idle high", sck, 1);
    chk(cs_rise_t - edge_t[23] == 8, "R8 release delay d=3", cs_rise_t - edge_t[23], 8);
    chk(mosi_bad == 0, "R5 mosi stable cpol1", mosi_bad, 0);
  endtask

  task automatic t_hold_pair();
    qw[0] = {8'd24, 24'hC35AF0}; qk[0] = 1'b1;
    qw[1] = {8'd5,  24'hB80000}; qk[1] = 1'b0; qn = 2;
    setup(2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 128'h5_9E3C_6A17_D2B4);
    wait_done();
    chk(ne == 58, "R3 edges for 24+5 bits", ne, 58);
    chk(edge_t[48] - edge_t[47] >= 12, "R7 gap between chunks", edge_t[48] - edge_t[47], 12);
    chk(ncr == 1, "R8 cs held across chunks", ncr, 1);
    chk(cs_rise_t - edge_t[57] == 6, "R8 release after second chunk", cs_rise_t - edge_t[57], 6);
    check_chunk("hold first R5", 0, 24'hC35AF0, 24, 0);
    check_chunk("hold second", 24, 24'hB80000, 5, 1);
    chk(mosi_bad == 0, "R5 mosi stable leading-out mode", mosi_bad, 0);
  endtask

  task automatic t_zero_word();
    qw[0] = {8'd8, 24'h6E0000}; qk[0] = 1'b1;
    qw[1] = {8'd0, 24'hFFFFFF}; qk[1] = 1'b0;
    qw[2] = {8'd8, 24'h190000}; qk[2] = 1'b0; qn = 3;
    setup(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 128'hA7C3);
    wait_done();
    chk(qidx == 3, "R10 zero word popped", qidx, 3);
    chk(ne == 32, "R10 no edges for zero word", ne, 32);
    chk(nr == 2, "R10 no push for zero word", nr, 2);
    chk(ncr == 1, "R10 cs unchanged by zero word", ncr, 1);
    chk(edge_t[16] - edge_t[15] >= 4, "R7 gap d=0", edge_t[16] - edge_t[15], 4);
    check_chunk("zero after", 8, 24'h190000, 8, 1);
  endtask

  task automatic t_clamp_status();
    qw[0] = {8'd40, 24'h123456}; qk[0] = 1'b0; qn = 1;
    setup(7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 128'hF0F0_3355);
    wait_done();
    chk(ne == 48, "R3 count clamped to 24", ne, 48);
    chk(bl_start == 24, "R9 bits_left at start", bl_start, 24);
    chk(busy_start == 1'b1, "R9 busy at start", busy_start, 1);
    chk(bits_left == 0 && !busy, "R9 idle at end", {busy, bits_left}, 0);
    check_chunk("mixed order", 0, 24'h123456, 24, 0);
  endtask

  task automatic t_mode3_mixed();
    qw[0] = {8'd16, 24'h9DE200}; qk[0] = 1'b0; qn = 1;
    setup(4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 128'h1_B7A9);
    wait_done();
    chk(ne == 32, "R3 edges for 16 bits", ne, 32);
    chk(edge_t[1] - edge_t[0] == 5, "R1 half period d=4", edge_t[1] - edge_t[0], 5);
    check_chunk("mode3 R5", 0, 24'h9DE200, 16, 0);
    chk(mosi_bad == 0, "R5 mosi stable mode3", mosi_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_mode0_msb();
    t_cpol1_lsb();
    t_hold_pair();
    t_zero_word();
    t_clamp_status();
    t_mode3_mixed();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule